// File: doc/BRIEF.md
# OFDM Subcarrier Frame Assembler

This block produces the frequency-domain sample stream that feeds an inverse FFT in an OFDM transmitter. For every symbol it walks a bin index through all FFT bins in natural order. At each bin it decides, from a programmable per-bin class table, whether to emit the next mapped data sample, a boosted pilot of fixed magnitude 4/3, or zero. Each frame opens with one preamble symbol in which every bin carries a ±4/3 value taken from a separate sign table. The preamble is followed by a fixed number of data symbols. Samples are signed fixed point with 14 fractional bits, so the boosted level is ±21845 at the default 16-bit width.

Mapped data arrives on a valid/ready handshake. When the walk reaches a data bin and no sample is waiting, the block holds its position and emits nothing, so a starved source never turns into inserted zeros. Software-side setup loads three tables through one write port: a 2-bit class per bin, a combined pilot sign per bin (the product of its individual and group phases), and a preamble sign per bin. With the default 1024 bins and 729 active carriers, the usual loading places active carrier k at bin (k − 364) mod 1024, so carrier 364 lands on the centre bin 0. The output carries start-of-symbol and start-of-frame flags, and it comes from a single register stage after the bin selection.

Top module: `ofdm_frame_assembler`

## Requirements
- R1: While reset is applied, and on the first cycle after it, out_valid, out_sos and out_sof are 0. After reset the walk restarts at bin 0 of the preamble symbol.
- R2: In the preamble symbol, every bin b outputs out_i = −BOOST if its preamble sign bit is 1 and +BOOST if it is 0 (BOOST = floor(4·2^14/3) = 21845), with out_q = 0. No input sample is consumed.
- R3: In a data symbol, a bin of class 2'b01 outputs the next input sample in arrival order on out_i/out_q. in_ready is 1 exactly when run is 1, the current symbol is a data symbol and the current bin has class 2'b01.
- R4: In a data symbol, a bin of class 2'b10 (pilot) outputs out_i = −BOOST if its pilot sign bit is 1 and +BOOST otherwise, with out_q = 0.
- R5: In a data symbol, a bin of class 2'b00 and a bin of the unused class 2'b11 both output 0 on out_i and out_q.
- R6: If the current bin is a data bin of a data symbol and in_valid is 0, the bin index holds and out_valid is 0 on the next cycle. No zero sample is substituted for the missing data.
- R7: out_sos is 1 on the output sample of bin 0 of every symbol and 0 on all others. out_sof is 1 only on bin 0 of the preamble, and out_sof implies out_sos.
- R8: A frame is one preamble symbol followed by SYMS_PER_FRAME data symbols, each of N_BINS bins emitted in the order 0..N_BINS−1, and frames repeat without a gap.
- R9: An output sample appears on the cycle after the clock edge at which its bin is selected, through exactly one register stage.
- R10: While run is 0, the walk holds, in_ready is 0, and out_valid is 0 on the next cycle.
- R11: A write with cfg_we = 1 stores cfg_data into the table chosen by cfg_sel at bin cfg_addr. cfg_sel 0 writes the class (cfg_data[1:0]), 1 writes the pilot sign (cfg_data[0]), 2 writes the preamble sign (cfg_data[0]), and 3 writes nothing. A rewritten entry takes effect the next time that bin is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allows the bin walk to advance |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select: 0 class, 1 pilot sign, 2 preamble sign |
| cfg_addr | input | IDX_W | Bin address of the table write |
| cfg_data | input | 2 | Write data (class uses both bits, signs use bit 0) |
| in_valid | input | 1 | Mapped data sample available |
| in_ready | output | 1 | Sample taken at this edge when in_valid is 1 |
| in_i | input | SAMPLE_W | In-phase data sample |
| in_q | input | SAMPLE_W | Quadrature data sample |
| out_valid | output | 1 | Output sample valid |
| out_sos | output | 1 | Output is bin 0 of a symbol |
| out_sof | output | 1 | Output is bin 0 of the preamble |
| out_i | output | SAMPLE_W | In-phase frequency-domain sample |
| out_q | output | SAMPLE_W | Quadrature frequency-domain sample |

## Verification
The functions most likely to collide are data starvation and the symbol and frame boundary. Bin 0 is a data bin in the test tables, so a missing input can arrive at the very cycle where a data symbol begins or a frame wraps. The bench provokes this with periodic gaps in in_valid and with pauses on run during a multi-frame run. It then requires that stalled cycles produce no valid output, and that out_sos and out_sof appear on the first valid sample of bin 0 rather than on the stalled cycle. Every valid sample is compared against a bin-and-symbol model kept in the bench from its own copy of the tables.

// File: rtl/ofdm_asm_pkg.sv
package ofdm_asm_pkg;

    localparam int FRAC_BITS = 14;
    localparam int BOOST_LEVEL = (4 << FRAC_BITS) / 3;

    typedef enum logic [1:0] {
        BIN_ZERO  = 2'b00,
        BIN_DATA  = 2'b01,
        BIN_PILOT = 2'b10,
        BIN_RSVD  = 2'b11
    } bin_class_e;

    typedef enum logic [1:0] {
        TBL_CLASS = 2'd0,
        TBL_PSIGN = 2'd1,
        TBL_PRE   = 2'd2,
        TBL_NONE  = 2'd3
    } tbl_sel_e;

    typedef struct packed {
        bin_class_e cls;
        logic       pilot_neg;
        logic       pre_neg;
    } bin_info_t;

    function automatic logic signed [31:0] boosted(input logic neg);
        return neg ? -32'sd1 * BOOST_LEVEL : 32'sd1 * BOOST_LEVEL;
    endfunction

endpackage

// File: rtl/asm_tables.sv
module asm_tables
    import ofdm_asm_pkg::*;
#(
    parameter int N_BINS = 1024,
    localparam int IDX_W = $clog2(N_BINS)
) (
    input  logic             clk,
    input  logic             we,
    input  tbl_sel_e         sel,
    input  logic [IDX_W-1:0] waddr,
    input  logic [1:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output bin_info_t        info
);

    logic [1:0] cls_mem   [N_BINS];
    logic       psign_mem [N_BINS];
    logic       pre_mem   [N_BINS];

    always_ff @(posedge clk) begin
        if (we) begin
            case (sel)
                TBL_CLASS: cls_mem[waddr]   <= wdata;
                TBL_PSIGN: psign_mem[waddr] <= wdata[0];
                TBL_PRE:   pre_mem[waddr]   <= wdata[0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        info.cls       = bin_class_e'(cls_mem[raddr]);
        info.pilot_neg = psign_mem[raddr];
        info.pre_neg   = pre_mem[raddr];
    end

endmodule

// File: rtl/asm_sequencer.sv
module asm_sequencer #(
    parameter int N_BINS = 1024,
    parameter int SYMS_PER_FRAME = 120,
    localparam int IDX_W = $clog2(N_BINS),
    localparam int SYM_W = $clog2(SYMS_PER_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             in_preamble
);

    localparam logic [IDX_W-1:0] LAST_BIN = IDX_W'(N_BINS - 1);
    localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(SYMS_PER_FRAME);

    logic [SYM_W-1:0] sym;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            sym <= '0;
        end else if (advance) begin
            if (idx == LAST_BIN) begin
                idx <= '0;
                sym <= (sym == LAST_SYM) ? '0 : sym + 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign in_preamble = (sym == '0);

endmodule

// File: rtl/asm_bin_mux.sv
module asm_bin_mux
    import ofdm_asm_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       in_preamble,
    input  bin_info_t                  info,
    input  logic signed [SAMPLE_W-1:0] data_i,
    input  logic signed [SAMPLE_W-1:0] data_q,
    output logic signed [SAMPLE_W-1:0] samp_i,
    output logic signed [SAMPLE_W-1:0] samp_q,
    output logic                       need_data
);

    always_comb begin
        samp_i    = '0;
        samp_q    = '0;
        need_data = 1'b0;
        if (in_preamble) begin
            samp_i = SAMPLE_W'(boosted(info.pre_neg));
        end else begin
            case (info.cls)
                BIN_DATA: begin
                    need_data = 1'b1;
                    samp_i    = data_i;
                    samp_q    = data_q;
                end
                BIN_PILOT: samp_i = SAMPLE_W'(boosted(info.pilot_neg));
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/ofdm_frame_assembler.sv
module ofdm_frame_assembler
    import ofdm_asm_pkg::*;
#(
    parameter int N_BINS = 1024,
    parameter int SYMS_PER_FRAME = 120,
    parameter int SAMPLE_W = 16,
    localparam int IDX_W = $clog2(N_BINS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_sel,
    input  logic [IDX_W-1:0]           cfg_addr,
    input  logic [1:0]                 cfg_data,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    output logic                       out_valid,
    output logic                       out_sos,
    output logic                       out_sof,
    output logic signed [SAMPLE_W-1:0] out_i,
    output logic signed [SAMPLE_W-1:0] out_q
);

    logic [IDX_W-1:0]           idx;
    logic                       in_preamble;
    bin_info_t                  info;
    logic signed [SAMPLE_W-1:0] samp_i, samp_q;
    logic                       need_data;
    logic                       advance;

    asm_tables #(.N_BINS(N_BINS)) u_tables (
        .clk   (clk),
        .we    (cfg_we),
        .sel   (tbl_sel_e'(cfg_sel)),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (idx),
        .info  (info)
    );

    asm_sequencer #(.N_BINS(N_BINS), .SYMS_PER_FRAME(SYMS_PER_FRAME)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .advance     (advance),
        .idx         (idx),
        .in_preamble (in_preamble)
    );

    asm_bin_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
        .in_preamble (in_preamble),
        .info        (info),
        .data_i      (in_i),
        .data_q      (in_q),
        .samp_i      (samp_i),
        .samp_q      (samp_q),
        .need_data   (need_data)
    );

    assign in_ready = run && need_data;
    assign advance  = run && !(need_data && !in_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sos   <= 1'b0;
            out_sof   <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= advance;
            out_sos   <= advance && (idx == '0);
            out_sof   <= advance && (idx == '0) && in_preamble;
            if (advance) begin
                out_i <= samp_i;
                out_q <= samp_q;
            end
        end
    end

endmodule

// File: rtl/ofdm_frame_assembler_chk.sv
module ofdm_frame_assembler_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_sos,
    input logic out_sof
);

    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            assert_reset_quiet_R1: assert (!out_valid && !out_sos && !out_sof)
                else $error("outputs active right after reset");
        end
    end

    assert_sof_in_sos_R7: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> (out_sos && out_valid));

    assert_take_emits_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    assert_starve_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !out_valid);

    assert_pause_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !run |=> !out_valid);

    assert_pause_no_take_R10: assert property (@(posedge clk) disable iff (rst)
        !run |-> !in_ready);

endmodule

bind ofdm_frame_assembler ofdm_frame_assembler_chk u_chk (.*);

// File: tb/sim_ofdm_frame_assembler.sv
module sim_ofdm_frame_assembler;

    localparam int NB = 16;
    localparam int NS = 2;
    localparam int W = 16;
    localparam int AW = $clog2(NB);
    localparam int BOOST = 21845;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [1:0] cfg_data = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [W-1:0] in_i = '0, in_q = '0;
    logic out_valid, out_sos, out_sof;
    logic signed [W-1:0] out_i, out_q;

    always #2 clk = ~clk;

    ofdm_frame_assembler #(.N_BINS(NB), .SYMS_PER_FRAME(NS), .SAMPLE_W(W)) u0 (
        .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
        .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
        .out_sos(out_sos), .out_sof(out_sof), .out_i(out_i), .out_q(out_q)
    );

    int checks = 0;
    int failures = 0;
    logic [1:0] cls_m [NB];
    logic ps_m [NB];
    logic pr_m [NB];
    int mb = 0, ms = 0, md = 0, n_in = 0;

    function automatic logic signed [W-1:0] fi(input int n);
        return W'(n * 37 + 5);
    endfunction
    function automatic logic signed [W-1:0] fq(input int n);
        return W'(-(n * 13) - 7);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input int addr, input logic [1:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = AW'(addr); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one cycle: drive at negedge, check result at next negedge
    task automatic step(input logic r, input logic v);
        logic exp_ready, stalled;
        int ei, eq;
        string tag;
        run = r; in_valid = v; in_i = fi(n_in); in_q = fq(n_in);
        #1;
        exp_ready = r && (ms != 0) && (cls_m[mb] == 2'b01);
        chk(in_ready == exp_ready, "R3 in_ready", int'(in_ready), int'(exp_ready));
        stalled = !r || (exp_ready && !v);
        if (in_ready && in_valid) n_in++;
        @(negedge clk);
        if (stalled) begin
            chk(!out_valid, r ? "R6 stall valid" : "R10 pause valid", int'(out_valid), 0);
        end else begin
            chk(out_valid, "R9 output valid", int'(out_valid), 1);
            if (ms == 0) begin
                tag = "R2 preamble"; ei = pr_m[mb] ? -BOOST : BOOST; eq = 0;
            end else if (cls_m[mb] == 2'b01) begin
                tag = "R3 data"; ei = int'(fi(md)); eq = int'(fq(md)); md++;
            end else if (cls_m[mb] == 2'b10) begin
                tag = "R4 pilot"; ei = ps_m[mb] ? -BOOST : BOOST; eq = 0;
            end else begin
                tag = "R5 zero"; ei = 0; eq = 0;
            end
            chk(int'(out_i) == ei, {tag, " I"}, int'(out_i), ei);
            chk(int'(out_q) == eq, {tag, " Q"}, int'(out_q), eq);
            chk(out_sos == (mb == 0), "R7 sos", int'(out_sos), int'(mb == 0));
            chk(out_sof == (mb == 0 && ms == 0), "R8 sof", int'(out_sof), int'(mb == 0 && ms == 0));
            if (mb == NB - 1) begin
                mb = 0;
                ms = (ms == NS) ? 0 : ms + 1;
            end else mb++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; run = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(!out_valid && !out_sos && !out_sof, "R1 reset outputs", int'(out_valid), 0);
        rst = 1'b0;
        mb = 0; ms = 0; md = n_in;
        @(negedge clk);
        chk(!out_valid, "R1 after release", int'(out_valid), 0);
    endtask

    task automatic t_load();
        for (int b = 0; b < NB; b++) begin
            if (b >= 7 && b <= 9) cls_m[b] = 2'b00;
            else if (b == 3 || b == 12) cls_m[b] = 2'b10;
            else if (b == 15) cls_m[b] = 2'b11;
            else cls_m[b] = 2'b01;
            ps_m[b] = (b == 12);
            pr_m[b] = b[0];
            cfg_write(2'd0, b, cls_m[b]);
            cfg_write(2'd1, b, {1'b0, ps_m[b]});
            cfg_write(2'd2, b, {1'b0, pr_m[b]});
        end
        // select 3 must not disturb any table (R11)
        cfg_write(2'd3, 3, 2'b11);
    endtask

    task automatic t_full_frames();
        for (int k = 0; k < 110; k++) step(1'b1, 1'b1);
    endtask

    task automatic t_starve();
        for (int k = 0; k < 100; k++) step(1'b1, (k % 3) != 0);
    endtask

    task automatic t_pause();
        for (int k = 0; k < 80; k++) step((k % 5) != 0, (k % 2) == 0);
    endtask

    task automatic t_rewrite();
        step(1'b0, 1'b0);
        cls_m[5] = 2'b10; ps_m[5] = 1'b1; cfg_write(2'd0, 5, 2'b10); cfg_write(2'd1, 5, 2'b01);
        ps_m[3] = 1'b1; cfg_write(2'd1, 3, 2'b01);
        pr_m[0] = 1'b1; cfg_write(2'd2, 0, 2'b01);
        cls_m[8] = 2'b11; cfg_write(2'd0, 8, 2'b11);
        for (int k = 0; k < 110; k++) step(1'b1, (k % 4) != 1);
    endtask

    task automatic t_mid_reset();
        for (int k = 0; k < 7; k++) step(1'b1, 1'b1);
        t_reset();
        for (int k = 0; k < 40; k++) step(1'b1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_full_frames();
        t_starve();
        t_pause();
        t_rewrite();
        t_mid_reset();
        report();
        $finish;
    end

endmodule